// File: doc/BRIEF.md
# Shadow Register Nonvolatile Store Controller

This block holds a small bank of configuration registers and keeps a copy of selected bits of each one in an external nonvolatile array. A host reads and writes the registers through a simple single-cycle register port. Writing a trigger word starts one of two operations. A program operation copies the storable bits of the bank into the array. A reload operation copies the array back over the storable bits of the bank. When power-on reset is released, the block starts a reload by itself, so the bank comes up with the stored values.

The controller handles one array word at a time. It visits only the registers that contain at least one storable bit, in rising index order. It holds each request until the array returns a one-cycle ready pulse. While an operation runs, `busy` is high and the host port is locked. A write is dropped. A read returns zero and raises `host_reject` for that cycle.

Top module: `shadow_nvm_ctrl`

## Requirements
- R1: A program operation sends each register to the array as `reg & mask`, where `mask` is that register's slice of `STORE_MASK`. Registers whose mask is zero get no array access.
- R2: A host write to address `NREG` (the trigger word) with bit 0 set starts a program operation. A later read of that address returns 0.
- R3: A host write to the trigger word with bit 1 set and bit 0 clear starts a reload operation. After the reload, a read of the trigger word returns 0.
- R4: A reload replaces the storable bits of each register with the array word. The register's other bits keep their values.
- R5: `busy` goes to 1 in the cycle after a trigger write is accepted. It stays 1 until the cycle after the ready pulse for the last storable register, then goes to 0.
- R6: A host write while `busy` is 1 has no effect on any register.
- R7: A host read while `busy` is 1 returns 0 on `host_rdata` and raises `host_reject` in the same cycle. With `busy` at 0, `host_reject` stays 0. A read of register address a < `NREG` returns that register, and any other read returns 0.
- R8: While reset is held and after it is released, `busy` is 1 and an automatic reload runs. Bits that are not storable hold their `RESET_VAL` values.
- R9: While a request is waiting, `nvm_addr`, `nvm_we` and `nvm_wdata` stay unchanged. Each ready pulse moves the controller to the next higher storable index.
- R10: A trigger write with bits 1 and 0 both set starts only a program operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | AW | Host address: 0..NREG-1 registers, NREG trigger word |
| host_wdata | input | DW | Host write data |
| host_rdata | output | DW | Read data, same cycle as `host_rd` |
| host_reject | output | 1 | Read refused because an operation is running |
| busy | output | 1 | Program or reload in progress |
| nvm_req | output | 1 | Array access request |
| nvm_we | output | 1 | 1 = program word, 0 = read word |
| nvm_addr | output | IW | Array word index |
| nvm_wdata | output | DW | Word to store (storable bits only) |
| nvm_ready | input | 1 | One-cycle completion pulse from the array |
| nvm_rdata | input | DW | Array word, valid with `nvm_ready` |

## Verification
A wrong word index or operation direction shows on `nvm_addr` and `nvm_we` in the first cycle of the operation. A sequencing error that skips, repeats or reorders words shows in the cycle after the ready pulse. If the busy flag were held or released at the wrong time, `busy` and `host_reject` would differ from the reference within one cycle. A bad merge during reload, or a lost write, does not appear until the host reads that register again. For that reason the bench reads every register back after each operation and after each reset.

// File: rtl/shadow_nvm_ctrl.sv
module shadow_nvm_ctrl #(
  parameter int NREG = 4,
  parameter int DW = 8,
  parameter logic [NREG*DW-1:0] STORE_MASK = 32'h00FF_0FF0,
  parameter logic [NREG*DW-1:0] RESET_VAL  = 32'h5AA5_3CC3,
  localparam int AW = $clog2(NREG + 1),
  localparam int IW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [AW-1:0] host_addr,
  input  logic [DW-1:0] host_wdata,
  output logic [DW-1:0] host_rdata,
  output logic          host_reject,
  output logic          busy,
  output logic          nvm_req,
  output logic          nvm_we,
  output logic [IW-1:0] nvm_addr,
  output logic [DW-1:0] nvm_wdata,
  input  logic          nvm_ready,
  input  logic [DW-1:0] nvm_rdata
);

  function automatic int first_stored();
    int r;
    r = -1;
    for (int i = 0; i < NREG; i++)
      if (r < 0 && STORE_MASK[i*DW +: DW] != '0) r = i;
    return (r < 0) ? 0 : r;
  endfunction

  function automatic int last_stored();
    int r;
    r = 0;
    for (int i = 0; i < NREG; i++)
      if (STORE_MASK[i*DW +: DW] != '0) r = i;
    return r;
  endfunction

  localparam int FIRST = first_stored();
  localparam int LAST  = last_stored();

  logic [DW-1:0]      regs [NREG];
  logic [NREG*DW-1:0] regs_flat;
  logic               op_prog;
  logic [IW-1:0]      idx, idx_nxt;
  logic [DW-1:0]      cur_mask;

  wire wr_ok    = host_wr && !busy;
  wire rd_ok    = host_rd && !busy;
  wire trig_hit = wr_ok && host_addr == AW'(NREG) && (host_wdata[0] || host_wdata[1]);
  wire step     = busy && nvm_ready;
  wire at_last  = idx == IW'(LAST);

  assign cur_mask = STORE_MASK[idx*DW +: DW];

  always_comb begin
    idx_nxt = idx;
    for (int i = NREG - 1; i >= 0; i--)
      if (i > int'(idx) && STORE_MASK[i*DW +: DW] != '0) idx_nxt = IW'(i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b1;
      op_prog <= 1'b0;
      idx     <= IW'(FIRST);
    end else if (trig_hit) begin
      busy    <= 1'b1;
      op_prog <= host_wdata[0];
      idx     <= IW'(FIRST);
    end else if (step) begin
      if (at_last) busy <= 1'b0;
      else         idx  <= idx_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= RESET_VAL[i*DW +: DW];
    end else begin
      for (int i = 0; i < NREG; i++) begin
        if (step && !op_prog && idx == IW'(i))
          regs[i] <= (regs[i] & ~STORE_MASK[i*DW +: DW]) | (nvm_rdata & STORE_MASK[i*DW +: DW]);
        else if (wr_ok && host_addr == AW'(i))
          regs[i] <= host_wdata;
      end
    end
  end

  always_comb
    for (int i = 0; i < NREG; i++) regs_flat[i*DW +: DW] = regs[i];

  assign nvm_req     = busy;
  assign nvm_we      = busy && op_prog;
  assign nvm_addr    = idx;
  assign nvm_wdata   = nvm_we ? (regs[idx] & cur_mask) : '0;
  assign host_reject = host_rd && busy;
  assign host_rdata  = (rd_ok && host_addr < AW'(NREG)) ? regs[host_addr[IW-1:0]] : '0;

endmodule

module shadow_nvm_ctrl_chk #(
  parameter int NREG = 4,
  parameter int DW = 8,
  parameter int AW = 3,
  parameter int IW = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               host_wr,
  input logic               host_rd,
  input logic [AW-1:0]      host_addr,
  input logic [1:0]         trig_bits,
  input logic [DW-1:0]      host_rdata,
  input logic               host_reject,
  input logic               busy,
  input logic               nvm_ready,
  input logic               nvm_we,
  input logic [IW-1:0]      nvm_addr,
  input logic [DW-1:0]      nvm_wdata,
  input logic               op_prog,
  input logic [NREG*DW-1:0] regs_flat
);

  // R5
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(host_wr && host_addr == AW'(NREG)));

  // R5
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !nvm_ready |=> busy);

  // R10
  both_bits_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && host_wr && host_addr == AW'(NREG) && trig_bits == 2'b11) |=> nvm_we);

  // R7
  reject_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_reject |-> (host_rdata == '0 && busy && host_rd));

  // R7
  no_reject_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !host_reject);

  // R6
  prog_regs_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && op_prog |=> $stable(regs_flat));

  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !nvm_ready |=> $stable(nvm_addr) && $stable(nvm_we) && $stable(nvm_wdata));

  // R9
  addr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && nvm_ready |=> (!busy || nvm_addr > $past(nvm_addr)));

endmodule

bind shadow_nvm_ctrl shadow_nvm_ctrl_chk #(.NREG(NREG), .DW(DW), .AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
  .trig_bits(host_wdata[1:0]), .host_rdata(host_rdata), .host_reject(host_reject),
  .busy(busy), .nvm_ready(nvm_ready), .nvm_we(nvm_we), .nvm_addr(nvm_addr),
  .nvm_wdata(nvm_wdata), .op_prog(op_prog), .regs_flat(regs_flat)
);

// File: tb/shadow_nvm_ctrl_tb.sv
`timescale 1ns/1ps
module shadow_nvm_ctrl_tb;
  localparam int NREG = 4;
  localparam int DW = 8;
  localparam int AW = $clog2(NREG + 1);
  localparam int IW = $clog2(NREG);
  localparam logic [NREG*DW-1:0] MASK = 32'h00FF_0FF0;
  localparam logic [NREG*DW-1:0] RVAL = 32'h5AA5_3CC3;
  localparam int WLAT = 3;
  localparam int RLAT = 2;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_rd = 0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [DW-1:0] host_rdata, nvm_wdata, rdat;
  logic host_reject, busy, nvm_req, nvm_we, rdy;
  logic [IW-1:0] nvm_addr;

  always #2 clk = ~clk;

  shadow_nvm_ctrl #(.NREG(NREG), .DW(DW), .STORE_MASK(MASK), .RESET_VAL(RVAL)) u_dut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .host_reject(host_reject), .busy(busy),
    .nvm_req(nvm_req), .nvm_we(nvm_we), .nvm_addr(nvm_addr), .nvm_wdata(nvm_wdata),
    .nvm_ready(rdy), .nvm_rdata(rdat));

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural nonvolatile array
  logic [DW-1:0] mem [NREG];
  int cnt;
  initial begin
    mem[0] = 8'h12; mem[1] = 8'h34; mem[2] = 8'h56; mem[3] = 8'h78;
  end
  always @(posedge clk) begin
    if (!rst_n || rdy) begin
      rdy <= 0; cnt <= 0;
    end else if (nvm_req) begin
      if (cnt >= (nvm_we ? WLAT : RLAT) - 1) begin
        rdy <= 1;
        rdat <= mem[nvm_addr];
        if (nvm_we) mem[nvm_addr] <= nvm_wdata;
      end else cnt <= cnt + 1;
    end
  end

  // reference model
  function automatic logic [DW-1:0] mk(int i);
    return MASK[i*DW +: DW];
  endfunction
  int stored[$];
  initial for (int i = 0; i < NREG; i++) if (mk(i) != '0) stored.push_back(i);

  logic [DW-1:0] m_reg [NREG];
  bit m_busy, m_prog;
  int m_pos;

  always @(negedge clk) begin
    #1;
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) m_reg[i] = RVAL[i*DW +: DW];
      m_busy = 1; m_prog = 0; m_pos = 0;
      chk("R8", "busy in reset", busy, 1);
    end else begin
      logic [DW-1:0] er;
      chk("R5", "busy", busy, m_busy);
      chk("R9", "nvm_req", nvm_req, m_busy);
      if (m_busy) begin
        chk("R9", "nvm_addr", nvm_addr, stored[m_pos]);
        chk("R2", "nvm_we", nvm_we, m_prog);
        if (m_prog) chk("R1", "nvm_wdata", nvm_wdata, m_reg[stored[m_pos]] & mk(stored[m_pos]));
      end
      er = (host_rd && !m_busy && host_addr < NREG) ? m_reg[host_addr] : '0;
      chk("R7", "host_rdata", host_rdata, er);
      chk("R7", "host_reject", host_reject, host_rd && m_busy);
      if (m_busy) begin
        if (rdy) begin
          int k;
          k = stored[m_pos];
          if (!m_prog) m_reg[k] = (m_reg[k] & ~mk(k)) | (mem[k] & mk(k));
          if (m_pos == stored.size() - 1) m_busy = 0;
          else m_pos++;
        end
      end else if (host_wr) begin
        if (host_addr < NREG) m_reg[host_addr] = host_wdata;
        else if (host_addr == NREG && host_wdata[1:0] != 0) begin
          m_busy = 1; m_prog = host_wdata[0]; m_pos = 0;
        end
      end
    end
  end

  task automatic hwrite(int a, logic [DW-1:0] d);
    @(negedge clk);
    host_wr = 1; host_addr = AW'(a); host_wdata = d;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic hread(int a, output logic [DW-1:0] d, output logic rej);
    @(negedge clk);
    host_rd = 1; host_addr = AW'(a);
    #1.5;
    d = host_rdata; rej = host_reject;
    @(negedge clk);
    host_rd = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic read_chk(string req, int a, logic [DW-1:0] exp);
    logic [DW-1:0] d; logic rj;
    hread(a, d, rj);
    chk(req, $sformatf("reg%0d readback", a), d, exp);
  endtask

  initial begin
    logic [DW-1:0] d; logic rj;
    repeat (3) @(negedge clk);
    chk("R8", "busy held during reset", busy, 1);
    rst_n = 1;
    wait_idle();
    // R8: storable bits from the array, others from reset values
    read_chk("R8", 0, 8'h13);
    read_chk("R8", 1, 8'h34);
    read_chk("R8", 2, 8'h56);
    read_chk("R8", 3, 8'h5A);

    hwrite(0, 8'hAB); hwrite(1, 8'hCD); hwrite(2, 8'hEF); hwrite(3, 8'h99);
    read_chk("R7", 3, 8'h99);
    hwrite(4, 8'h01);
    #1;
    chk("R5", "busy right after program trigger", busy, 1);
    hwrite(0, 8'h00);
    hread(1, d, rj);
    chk("R7", "blocked read data", d, 0);
    chk("R7", "blocked read reject", rj, 1);
    wait_idle();
    read_chk("R6", 0, 8'hAB);
    chk("R1", "array word 0", mem[0], 8'hA0);
    chk("R1", "array word 1", mem[1], 8'h0D);
    chk("R1", "array word 2", mem[2], 8'hEF);
    chk("R1", "array word 3 untouched", mem[3], 8'h78);
    read_chk("R2", 4, 8'h00);

    hwrite(0, 8'h55); hwrite(1, 8'h66); hwrite(2, 8'h77); hwrite(3, 8'h11);
    hwrite(4, 8'h02);
    hwrite(3, 8'hFF);
    wait_idle();
    read_chk("R4", 0, 8'hA5);
    read_chk("R4", 1, 8'h6D);
    read_chk("R4", 2, 8'hEF);
    read_chk("R6", 3, 8'h11);
    read_chk("R3", 4, 8'h00);

    hwrite(2, 8'h3C);
    hwrite(4, 8'h03);
    wait_idle();
    chk("R10", "program won, array word 2", mem[2], 8'h3C);
    read_chk("R10", 2, 8'h3C);

    @(negedge clk); rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    wait_idle();
    read_chk("R8", 0, 8'hA3);
    read_chk("R8", 1, 8'h3D);
    read_chk("R8", 2, 8'h3C);
    read_chk("R8", 3, 8'h5A);
    hread(1, d, rj);
    chk("R7", "no reject when idle", rj, 0);

    repeat (2) @(negedge clk);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule